// File: doc/BRIEF.md
# Byte-Wide One-Time-Programmable Memory Read Port

This block is a clock-based, synthesizable model of a byte-wide memory that can be programmed once. It has two active-low controls: a chip select and an output gate. The host presents an address and drops both controls. The block then reports the stored byte once three waits have all run out: the address wait, the select wait and the gate wait. Each wait is a parameter counted in clock edges. When either control is raised, the block keeps driving the data bus for a set number of cycles before the bus floats. Any change to the address or to a control cancels valid data at once, so there is no hold time.

Two side flags widen the behaviour. The first is an identification flag, which stands for an over-voltage on one address line. While it is set, the block returns one of two fixed identifier bytes in place of the array contents. The second is a programming-supply flag. While it is set, the read path is turned off and the block is either programming or programming-inhibited. Programming can only clear bits. Every cell starts out erased, with all ones. All controls are sampled on the clock edge, and every output comes from a register or a counter.

Top module: `otp_rdport`

## Requirements
- R1: `mode` reports the decoded state from the controls sampled at the last edge. The codes are 0 standby, 1 read, 2 output off, 3 identification, 4 program and 5 program inhibit. When the supply flag is set, the result is 4 if the select is low and 5 if it is high. Otherwise a high select gives 0, a high gate gives 2, the identification flag gives 3, and the remaining case gives 1.
- R2: In read mode, valid data is the stored byte at index `addr[STORE_W-1:0]`. Addresses that share those low bits refer to the same cell.
- R3: In identification mode, valid data is 0x1E when `addr[0]` is 0 and 0x0D when `addr[0]` is 1.
- R4: `dout_vld` is 1 only in read or identification mode, and only when three conditions have held for enough consecutive edges. The address together with the identification flag must be unchanged for ACC_CYC edges, the select low for CE_CYC edges, and the gate low for OE_CYC edges. Each count includes the edge that first samples the new value.
- R5: `dout_vld` falls right after the edge that samples a changed address or a raised control. `dout` is 0 whenever `dout_vld` is 0.
- R6: `dout_oe` is 1 in read and identification modes. After the edge that leaves those modes, it stays 1 for DF_CYC more cycles and is then 0. In every other case it is 0.
- R7: After reset, every cell reads 0xFF.
- R8: Every edge spent in program mode replaces the addressed cell with its bitwise AND with `prog_data`. A bit that is 0 can never return to 1, and program inhibit changes no cell.
- R9: While reset is held and right after it is released, `mode` is 0, `dout_oe` is 0 and `dout_vld` is 0.
- R10: While the sampled supply flag is set, `dout_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; erases the array |
| addr | input | ADDR_W | Byte address |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output gate |
| id_hv | input | 1 | Identification over-voltage flag |
| vpp_on | input | 1 | Programming supply present |
| prog_data | input | DATA_W | Byte to be ANDed into the cell during programming |
| dout | output | DATA_W | Data bus value (0 when not valid) |
| dout_oe | output | 1 | Bus is being driven |
| dout_vld | output | 1 | Data on `dout` is valid |
| mode | output | 3 | Decoded operating mode |

## Verification
Some properties are checked by assertions on every cycle. Valid data never appears while the supply flag is sampled set. Valid data always comes with a driven bus. Data stays stable for as long as it remains valid. The bus is still driven in the cycle right after read mode is left. A select or gate wait counter can never report done once its control has gone high. A programming write never raises a bit. The exact edge on which each wait runs out, and the last cycle of the float window, can only be seen in the bench's scenarios. The same holds for the identifier bytes, address aliasing, and the ordering of cleared bits across program pulses. The bench checks all of these against its own cycle model.

// File: rtl/otp_pkg.sv
package otp_pkg;

   typedef enum logic [2:0] {
      MD_STANDBY = 3'd0,
      MD_READ    = 3'd1,
      MD_OUTDIS  = 3'd2,
      MD_IDENT   = 3'd3,
      MD_PROG    = 3'd4,
      MD_INHIBIT = 3'd5
   } otp_mode_e;

endpackage

// File: rtl/otp_hold_timer.sv
// Counts consecutive edges on which a condition has held, saturating at LIMIT.
module otp_hold_timer #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic restart,
   output logic done
);
   localparam int CW = $clog2(LIMIT + 2);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (!hold)            cnt <= '0;
      else if (restart)          cnt <= CW'(1);
      else if (cnt < CW'(LIMIT)) cnt <= cnt + CW'(1);
   end

   assign done = (cnt >= CW'(LIMIT));

   // R4: a dropped condition clears the wait on the next edge
   a_r4_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && LIMIT > 0) |=> !done);

endmodule

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
   import otp_pkg::*;
(
   input  logic      ce_n,
   input  logic      oe_n,
   input  logic      id_hv,
   input  logic      vpp_on,
   output otp_mode_e mode
);
   always_comb begin
      if (vpp_on)     mode = ce_n ? MD_INHIBIT : MD_PROG;
      else if (ce_n)  mode = MD_STANDBY;
      else if (oe_n)  mode = MD_OUTDIS;
      else if (id_hv) mode = MD_IDENT;
      else            mode = MD_READ;
   end
endmodule

// File: rtl/otp_cell_array.sv
// Storage that starts erased (all ones); writes may only clear bits.
module otp_cell_array #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] idx,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
      end else if (wr_en) begin
         cells[idx] <= cells[idx] & wr_data;
      end
   end

   assign rd_data = cells[idx];

   // R8: a programming write never raises a bit of the cell it touches
   a_r8_no_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((cells[$past(idx)] & ~$past(rd_data)) == '0));

endmodule

// File: rtl/otp_rdport.sv
module otp_rdport
   import otp_pkg::*;
#(
   parameter int          ADDR_W   = 16,
   parameter int          DATA_W   = 8,
   parameter int          STORE_W  = 8,
   parameter int          ACC_CYC  = 4,
   parameter int          CE_CYC   = 4,
   parameter int          OE_CYC   = 2,
   parameter int          DF_CYC   = 2,
   parameter logic [7:0]  MFR_CODE = 8'h1E,
   parameter logic [7:0]  DEV_CODE = 8'h0D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              id_hv,
   input  logic              vpp_on,
   input  logic [DATA_W-1:0] prog_data,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe,
   output logic              dout_vld,
   output logic [2:0]        mode
);
   localparam int DFW = $clog2(DF_CYC + 2);

   generate
      if (STORE_W < 1 || STORE_W > ADDR_W) begin : g_bad_store
         $error("STORE_W must lie between 1 and ADDR_W");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must hold the identifier bytes");
      end
      if (ACC_CYC < 0 || CE_CYC < 0 || OE_CYC < 0 || DF_CYC < 0) begin : g_bad_delay
         $error("delay counts must not be negative");
      end
   endgenerate

   // sampled controls
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] din_q;
   logic              hv_q, ce_q, oe_q, vpp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         din_q  <= '1;
         hv_q   <= 1'b0;
         ce_q   <= 1'b1;
         oe_q   <= 1'b1;
         vpp_q  <= 1'b0;
      end else begin
         addr_q <= addr;
         din_q  <= prog_data;
         hv_q   <= id_hv;
         ce_q   <= ce_n;
         oe_q   <= oe_n;
         vpp_q  <= vpp_on;
      end
   end

   // three independent wait paths
   logic addr_chg, acc_done, ce_done, oe_done;
   assign addr_chg = ({id_hv, addr} != {hv_q, addr_q});

   otp_hold_timer #(.LIMIT(ACC_CYC)) u_acc_tmr (
      .clk(clk), .rst_n(rst_n), .hold(1'b1), .restart(addr_chg), .done(acc_done));
   otp_hold_timer #(.LIMIT(CE_CYC)) u_ce_tmr (
      .clk(clk), .rst_n(rst_n), .hold(!ce_n), .restart(1'b0), .done(ce_done));
   otp_hold_timer #(.LIMIT(OE_CYC)) u_oe_tmr (
      .clk(clk), .rst_n(rst_n), .hold(!oe_n), .restart(1'b0), .done(oe_done));

   // mode decode on sampled controls
   otp_mode_e md;
   otp_mode_dec u_dec (
      .ce_n(ce_q), .oe_n(oe_q), .id_hv(hv_q), .vpp_on(vpp_q), .mode(md));
   assign mode = md;

   logic en_mode;
   assign en_mode = (md == MD_READ) || (md == MD_IDENT);

   // storage
   logic [DATA_W-1:0] cell_rd;
   otp_cell_array #(.AW(STORE_W), .DW(DATA_W)) u_cells (
      .clk(clk), .rst_n(rst_n), .wr_en(md == MD_PROG),
      .idx(addr_q[STORE_W-1:0]), .wr_data(din_q), .rd_data(cell_rd));

   logic [DATA_W-1:0] id_byte, sel_byte;
   assign id_byte  = addr_q[0] ? DATA_W'(DEV_CODE) : DATA_W'(MFR_CODE);
   assign sel_byte = (md == MD_IDENT) ? id_byte : cell_rd;

   assign dout_vld = en_mode && acc_done && ce_done && oe_done;
   assign dout     = dout_vld ? sel_byte : '0;

   // float delay variant
   logic float_on;
   generate
      if (DF_CYC == 0) begin : g_nofloat
         assign float_on = 1'b0;
      end else begin : g_float
         logic [DFW-1:0] df_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             df_cnt <= '0;
            else if (en_mode)       df_cnt <= DFW'(DF_CYC);
            else if (df_cnt != '0)  df_cnt <= df_cnt - DFW'(1);
         end
         assign float_on = (df_cnt != '0);
      end
   endgenerate

   assign dout_oe = en_mode || float_on;

   // R10: supply flag blocks the read path
   a_r10_no_read_under_vpp: assert property (@(posedge clk) disable iff (!rst_n)
      vpp_q |-> !dout_vld);
   // R6: valid data is always driven
   a_r6_valid_driven: assert property (@(posedge clk) disable iff (!rst_n)
      dout_vld |-> dout_oe);
   // R6: bus still driven in the first cycle after leaving read modes
   a_r6_float_window: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en_mode) && !en_mode && DF_CYC > 0) |-> dout_oe);
   // R5: data stays stable while it remains valid
   a_r5_stable_data: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_vld && $past(dout_vld)) |-> $stable(dout));

endmodule

// File: tb/tb_otp_rdport.sv
`timescale 1ns/1ps
module tb_otp_rdport;
   localparam int ACC = 4, CEC = 4, OEC = 2, DF = 2, SW = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic        ce_n = 1'b1, oe_n = 1'b1, id_hv = 1'b0, vpp_on = 1'b0;
   logic [7:0]  prog_data = 8'hFF;
   logic [7:0]  dout;
   logic        dout_oe, dout_vld;
   logic [2:0]  mode;

   int n_chk = 0, n_fail = 0;
   bit run_cmp = 1'b0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   otp_rdport #(.ADDR_W(16), .DATA_W(8), .STORE_W(SW), .ACC_CYC(ACC),
                .CE_CYC(CEC), .OE_CYC(OEC), .DF_CYC(DF)) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
      .id_hv(id_hv), .vpp_on(vpp_on), .prog_data(prog_data),
      .dout(dout), .dout_oe(dout_oe), .dout_vld(dout_vld), .mode(mode));

   // ---------------- reference model built from the requirements
   logic [7:0]  m_mem [1 << SW];
   int          m_acc, m_ce, m_oe, m_df;
   logic [15:0] m_addr_q;
   logic [7:0]  m_din_q;
   logic        m_hv_q, m_ce_q, m_oe_q, m_vpp_q;

   function automatic logic [2:0] exp_mode();
      if (m_vpp_q)     return m_ce_q ? 3'd5 : 3'd4;
      if (m_ce_q)      return 3'd0;
      if (m_oe_q)      return 3'd2;
      if (m_hv_q)      return 3'd3;
      return 3'd1;
   endfunction

   function automatic bit exp_en();
      return (exp_mode() == 3'd1) || (exp_mode() == 3'd3);
   endfunction

   function automatic bit exp_vld();
      return exp_en() && m_acc >= ACC && m_ce >= CEC && m_oe >= OEC;
   endfunction

   function automatic logic [7:0] exp_dout();
      if (!exp_vld()) return 8'h00;
      if (exp_mode() == 3'd3) return m_addr_q[0] ? 8'h0D : 8'h1E;
      return m_mem[m_addr_q[SW-1:0]];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < (1 << SW); i++) m_mem[i] = 8'hFF;
         m_acc = 0; m_ce = 0; m_oe = 0; m_df = 0;
         m_addr_q = '0; m_din_q = 8'hFF;
         m_hv_q = 0; m_ce_q = 1; m_oe_q = 1; m_vpp_q = 0;
      end else begin
         bit en_pre;
         en_pre = exp_en();
         if (m_vpp_q && !m_ce_q) m_mem[m_addr_q[SW-1:0]] = m_mem[m_addr_q[SW-1:0]] & m_din_q;
         if ({id_hv, addr} != {m_hv_q, m_addr_q}) m_acc = 1;
         else if (m_acc < 1000) m_acc++;
         m_ce = ce_n ? 0 : ((m_ce < 1000) ? m_ce + 1 : m_ce);
         m_oe = oe_n ? 0 : ((m_oe < 1000) ? m_oe + 1 : m_oe);
         m_df = en_pre ? DF : ((m_df > 0) ? m_df - 1 : 0);
         m_addr_q = addr; m_din_q = prog_data; m_hv_q = id_hv;
         m_ce_q = ce_n; m_oe_q = oe_n; m_vpp_q = vpp_on;
      end
   end

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && run_cmp) begin
         chk("R1", "mode", 32'(mode), 32'(exp_mode()));
         chk("R4", "dout_vld", 32'(dout_vld), 32'(exp_vld()));
         chk("R6", "dout_oe", 32'(dout_oe), 32'(exp_en() || m_df != 0));
         chk(exp_mode() == 3'd3 ? "R3" : "R2", "dout", 32'(dout), 32'(exp_dout()));
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   // drives a read request with both controls low
   task automatic open_read(logic [15:0] a, logic hv);
      addr = a; id_hv = hv; ce_n = 1'b0; oe_n = 1'b0; vpp_on = 1'b0;
   endtask

   task automatic program_byte(logic [15:0] a, logic [7:0] d);
      addr = a; prog_data = d; vpp_on = 1'b1; ce_n = 1'b0; oe_n = 1'b1;
      step(3);
      ce_n = 1'b1;
      step(2);
      chk("R1", "inhibit mode", 32'(mode), 32'd5);
      vpp_on = 1'b0; prog_data = 8'hFF;
      step(2);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      step(3);
      chk("R9", "mode in reset", 32'(mode), 32'd0);
      chk("R9", "dout_oe in reset", 32'(dout_oe), 32'd0);
      rst_n = 1'b1;
      step(1);
      chk("R9", "dout_vld after reset", 32'(dout_vld), 32'd0);
      chk("R9", "mode after reset", 32'(mode), 32'd0);
      run_cmp = 1'b1;

      // R7: erased contents
      open_read(16'h1204, 1'b0);
      step(ACC - 1);
      chk("R4", "not yet valid", 32'(dout_vld), 32'd0);
      step(1);
      chk("R4", "valid at limit", 32'(dout_vld), 32'd1);
      chk("R7", "erased byte", 32'(dout), 32'hFF);

      // R5: address change cancels at once
      addr = 16'h1205;
      step(1);
      chk("R5", "vld drops", 32'(dout_vld), 32'd0);
      chk("R5", "dout zero", 32'(dout), 32'd0);
      ce_n = 1'b1; oe_n = 1'b1;
      step(DF + 1);

      // R8: programming only clears bits
      program_byte(16'h0003, 8'h05);
      open_read(16'hAB03, 1'b0);
      step(CEC);
      chk("R2", "alias read", 32'(dout), 32'h05);
      ce_n = 1'b1; oe_n = 1'b1; step(DF + 1);
      program_byte(16'h0003, 8'hF0);
      program_byte(16'h0003, 8'hFF);
      open_read(16'h0003, 1'b0);
      step(CEC);
      chk("R8", "bits stay cleared", 32'(dout), 32'h00);

      // R6: float window after the gate rises
      oe_n = 1'b1;
      step(1);
      chk("R1", "output off", 32'(mode), 32'd2);
      chk("R6", "float hold 1", 32'(dout_oe), 32'd1);
      step(DF - 1);
      chk("R6", "float hold last", 32'(dout_oe), 32'd1);
      step(1);
      chk("R6", "floated", 32'(dout_oe), 32'd0);
      oe_n = 1'b0;
      step(OEC - 1);
      chk("R4", "gate wait pending", 32'(dout_vld), 32'd0);
      step(1);
      chk("R4", "gate wait met", 32'(dout_vld), 32'd1);

      // R3: identifier bytes
      open_read(16'h0200, 1'b1);
      step(ACC);
      chk("R3", "maker byte", 32'(dout), 32'h1E);
      addr = 16'h0201;
      step(ACC);
      chk("R3", "device byte", 32'(dout), 32'h0D);

      // R10: supply flag with both controls low
      prog_data = 8'hFF; vpp_on = 1'b1; oe_n = 1'b0; id_hv = 1'b0; addr = 16'h0007;
      step(ACC + 2);
      chk("R10", "no read under supply", 32'(dout_vld), 32'd0);
      chk("R1", "program mode", 32'(mode), 32'd4);
      vpp_on = 1'b0; ce_n = 1'b1;
      step(1);
      chk("R1", "standby", 32'(mode), 32'd0);
      step(DF + 1);

      // random traffic
      for (int c = 0; c < 6000; c++) begin
         int r;
         r = int'($urandom % 10);
         case (r)
            0, 1: addr = 16'($urandom) & 16'hFF07;
            2:    ce_n = ~ce_n;
            3:    oe_n = ~oe_n;
            4:    id_hv = ($urandom % 4) == 0;
            5:    vpp_on = ($urandom % 6) == 0;
            6:    prog_data = 8'($urandom) | 8'($urandom);
            default: ;
         endcase
         step(1);
      end
      run_cmp = 1'b0;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule